// File: doc/BRIEF.md
# Parallel Port Handshake Sequencer

This block runs one word transfer between a host and a peripheral on a 16-bit parallel port. It drives a control strobe and a direction line, and it watches a peripheral flag and a peripheral status line. The host asks for a transfer with a one-cycle start request. With the request it gives the direction and picks one of two handshake modes: full, where the peripheral takes the flag to busy and back to ready, or pulse, where a short flag pulse is the acknowledge. The block reports busy, a one-cycle done, a one-cycle timeout and a one-cycle refusal when the status gate blocks the transfer.

A start is accepted only when the peripheral status reads ok. The block then waits for the flag to read ready. It holds the direction line steady before it raises the strobe. A programmable watchdog measures how long the strobe has been raised without the interface becoming ready again. When the limit runs out, the block raises the strobe for one more cycle, drops it, and drives an active-low peripheral reset for a fixed number of clock cycles. The active sense of the strobe, the flag and the status line is chosen by configuration inputs. Peripheral inputs go through a synchronizer before they are used.

Top module: `pport_handshake_seq`

## Requirements
- R1: While reset is applied and on the first cycle after it, busy, done, timeout and refusal are low. The peripheral reset output is high, the direction output is low and the strobe sits at its inactive level.
- R2: A start that arrives while the status line reads not-ok (logical 0) gives a one-cycle refusal pulse. Busy stays low and the strobe is never raised.
- R3: After an accepted start, the strobe is not raised until the flag reads ready (logical 1). The direction output carries the requested direction (1 = input from the peripheral, 0 = output to it) before the strobe rises.
- R4: In full mode the strobe drops once the flag reads busy. Done is not given while the flag stays busy, and it is given after the flag returns to ready.
- R5: In pulse mode the strobe drops and done is given once the flag reads busy. The return of the flag to ready is not waited for.
- R6: Done is high for exactly one cycle per completed word.
- R7: If the interface has not become ready within the limit of L cycles, counted from the first strobe cycle, a one-cycle timeout pulse is given. The strobe stays active for one further cycle, then drops. The peripheral reset output then goes low for exactly RST_CYC cycles, after which the block is idle. A stalled strobe is therefore active for L+1 cycles.
- R8: A timeout limit of 0 disables the watchdog: no timeout occurs however long the strobe stays raised.
- R9: Each polarity bit set to 1 makes its line active-low (strobe out, flag ready, status ok). Set to 0, the line is active-high.
- R10: Busy is high from the cycle after an accepted start until the block returns to idle, and it is low after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle transfer request |
| dir_in_i | input | 1 | Requested direction, 1 = input from peripheral |
| mode_pulse_i | input | 1 | 1 = pulse handshake, 0 = full handshake |
| pol_ctl_i | input | 1 | Strobe sense, 1 = active-low |
| pol_flg_i | input | 1 | Flag sense, 1 = ready when low |
| pol_sts_i | input | 1 | Status sense, 1 = ok when low |
| to_limit_i | input | TO_W | Timeout limit in cycles, 0 disables |
| pflg_i | input | 1 | Peripheral flag line |
| psts_i | input | 1 | Peripheral status line |
| pctl_o | output | 1 | Control strobe line |
| io_o | output | 1 | Direction line, high = input |
| preset_n_o | output | 1 | Active-low peripheral reset |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle word complete |
| timeout_o | output | 1 | One-cycle watchdog expiry |
| sts_fail_o | output | 1 | One-cycle refusal by status gate |

## Verification
The transfer is tried with every combination that changes its course: both handshake modes, both directions, and several mixes of line polarity. Some of these start with the status not-ok, to separate acceptance from refusal. A flag that reads busy when the start arrives shows whether the ready check holds back the strobe. A flag held busy after the acknowledge tells the two modes apart, since full mode must wait and pulse mode must not. Two stalls, one with no acknowledge and one with the flag stuck busy, time the strobe and reset widths exactly. A zero limit shows that the watchdog is switched off.

// File: rtl/pport_pkg.sv
package pport_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT_RDY = 3'd1,
    ST_STROBE   = 3'd2,
    ST_RELEASE  = 3'd3,
    ST_TO_SET   = 3'd4,
    ST_TO_RST   = 3'd5
  } seq_state_e;

  localparam int unsigned PPORT_IN_LINES = 2;

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= d_i;
      end
      assign q_o = stg_q;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], d_i};
      end
      assign q_o = stg_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pport_watchdog.sv
module pport_watchdog #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = run_i | (cnt_q != '0);

  always_comb begin
    if (run_i) cnt_d = cnt_q + 1'b1;
    else       cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = run_i && (limit_i != '0) && (cnt_q == limit_i - 1'b1);

  // R7: the count never passes the limit while the strobe window is open
  assert_cnt_below_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && limit_i != '0) |-> (cnt_q < limit_i));

endmodule

// File: rtl/pport_rst_pulse.sv
module pport_rst_pulse #(
  parameter int unsigned PULSE_CYC = 3750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic active_o,
  output logic last_o
);

  localparam int unsigned CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = fire_i | (cnt_q != '0);

  always_comb begin
    if (fire_i) cnt_d = CW'(PULSE_CYC);
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);
  assign last_o   = (cnt_q == CW'(1));

  // R7: a new reset request never lands on a pulse still in progress
  assert_no_retrigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |-> !active_o);

endmodule

// File: rtl/pport_handshake_seq.sv
module pport_handshake_seq
  import pport_pkg::*;
#(
  parameter int unsigned TO_W        = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_CYC     = 3750
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            dir_in_i,
  input  logic            mode_pulse_i,
  input  logic            pol_ctl_i,
  input  logic            pol_flg_i,
  input  logic            pol_sts_i,
  input  logic [TO_W-1:0] to_limit_i,
  input  logic            pflg_i,
  input  logic            psts_i,
  output logic            pctl_o,
  output logic            io_o,
  output logic            preset_n_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            timeout_o,
  output logic            sts_fail_o
);

  localparam int unsigned NIN = PPORT_IN_LINES;

  seq_state_e     state_q, state_d;
  logic           io_q, io_d;
  logic           mode_q, mode_d;
  logic           done_q, done_d;
  logic           sfail_q, sfail_d;
  logic [NIN-1:0] in_s;
  logic           flg_rdy, sts_ok;
  logic           pctl_act, wd_run, wd_expire;
  logic           rp_fire, rp_active, rp_last;

  pport_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({pflg_i, psts_i}),
    .q_o   (in_s)
  );

  assign flg_rdy = in_s[1] ^ pol_flg_i;
  assign sts_ok  = in_s[0] ^ pol_sts_i;

  pport_watchdog #(.CNT_W(TO_W)) u_wdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (wd_run),
    .limit_i  (to_limit_i),
    .expire_o (wd_expire)
  );

  pport_rst_pulse #(.PULSE_CYC(RST_CYC)) u_rpulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_i   (rp_fire),
    .active_o (rp_active),
    .last_o   (rp_last)
  );

  always_comb begin
    state_d = state_q;
    io_d    = io_q;
    mode_d  = mode_q;
    done_d  = 1'b0;
    sfail_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (sts_ok) begin
            io_d    = dir_in_i;
            mode_d  = mode_pulse_i;
            state_d = ST_WAIT_RDY;
          end else begin
            sfail_d = 1'b1;
          end
        end
      end
      ST_WAIT_RDY: begin
        if (flg_rdy) state_d = ST_STROBE;
      end
      ST_STROBE: begin
        if (wd_expire) begin
          state_d = ST_TO_SET;
        end else if (!flg_rdy) begin
          if (mode_q) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_RELEASE;
          end
        end
      end
      ST_RELEASE: begin
        if (wd_expire) begin
          state_d = ST_TO_SET;
        end else if (flg_rdy) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      ST_TO_SET: state_d = ST_TO_RST;
      ST_TO_RST: begin
        if (rp_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      io_q    <= 1'b0;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
      sfail_q <= 1'b0;
    end else begin
      state_q <= state_d;
      io_q    <= io_d;
      mode_q  <= mode_d;
      done_q  <= done_d;
      sfail_q <= sfail_d;
    end
  end

  assign pctl_act   = (state_q == ST_STROBE) || (state_q == ST_TO_SET);
  assign wd_run     = (state_q == ST_STROBE) || (state_q == ST_RELEASE);
  assign rp_fire    = (state_q == ST_TO_SET);

  assign pctl_o     = pctl_act ^ pol_ctl_i;
  assign io_o       = io_q;
  assign preset_n_o = ~rp_active;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign timeout_o  = rp_fire;
  assign sts_fail_o = sfail_q;

  // R6: done never lasts beyond one cycle
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: the peripheral reset only starts right after a timeout report
  assert_preset_after_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(preset_n_o) |-> $past(timeout_o));

  // R2: a refusal is reported only while the sequencer is idle
  assert_refuse_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sts_fail_o |-> !busy_o);

  // R8: a zero limit never lets the watchdog fire
  assert_no_expire_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (to_limit_i == '0) |-> !wd_expire);

  // R3: direction is already settled when the strobe rises
  assert_io_settled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pctl_act) |-> $stable(io_q));

endmodule

// File: tb/pport_handshake_seq_tb.sv
`timescale 1ns/1ps
module pport_handshake_seq_tb;

  localparam int unsigned TO_W    = 16;
  localparam int unsigned RST_CYC = 40;
  localparam int unsigned LIM     = 30;

  // {mode_pulse, dir_in, pol_ctl, pol_flg, pol_sts, status_ok}
  localparam logic [5:0] VEC [8] = '{
    6'b000001, 6'b011001, 6'b000101, 6'b110011,
    6'b011111, 6'b000000, 6'b110010, 6'b001111
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start_i, dir_in_i, mode_pulse_i;
  logic            pol_ctl, pol_flg, pol_sts;
  logic [TO_W-1:0] to_limit;
  logic            pflg, psts;
  logic            pctl_o, io_o, preset_n_o, busy_o, done_o, timeout_o, sts_fail_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pport_handshake_seq #(.TO_W(TO_W), .SYNC_STAGES(2), .RST_CYC(RST_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_in_i(dir_in_i),
    .mode_pulse_i(mode_pulse_i), .pol_ctl_i(pol_ctl), .pol_flg_i(pol_flg),
    .pol_sts_i(pol_sts), .to_limit_i(to_limit), .pflg_i(pflg), .psts_i(psts),
    .pctl_o(pctl_o), .io_o(io_o), .preset_n_o(preset_n_o), .busy_o(busy_o),
    .done_o(done_o), .timeout_o(timeout_o), .sts_fail_o(sts_fail_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit pctl_on();
    return pctl_o != pol_ctl;
  endfunction

  task automatic set_flag(input bit ready);
    pflg = ready ^ pol_flg;
  endtask

  task automatic set_cfg(input logic [5:0] v);
    mode_pulse_i = v[5];
    dir_in_i     = v[4];
    pol_ctl      = v[3];
    pol_flg      = v[2];
    pol_sts      = v[1];
    psts         = v[0] ^ v[1];
    set_flag(1'b1);
    repeat (4) @(negedge clk);
  endtask

  task automatic fire_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_pctl(input bit want, output int n);
    n = 0;
    while (pctl_on() != want && n < 60) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done_o && n < 30) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_vec(input logic [5:0] v);
    int  n;
    bit  seen, bad, early;
    set_cfg(v);
    chk(pctl_o == v[3], "R9 idle strobe level", pctl_o, v[3]);
    fire_start();
    if (!v[0]) begin
      seen = 0; bad = 0;
      for (int k = 0; k < 5; k++) begin
        if (sts_fail_o) seen = 1;
        if (busy_o || pctl_on()) bad = 1;
        @(negedge clk);
      end
      chk(seen, "R2 refusal pulse", seen, 1);
      chk(!bad, "R2 no busy/strobe on refusal", bad, 0);
    end else begin
      wait_pctl(1'b1, n);
      chk(n < 60, "R3 strobe raised", n, 0);
      chk(io_o == v[4], "R3 direction line", io_o, v[4]);
      chk(busy_o, "R10 busy during transfer", busy_o, 1);
      set_flag(1'b0);
      if (!v[5]) begin
        wait_pctl(1'b0, n);
        chk(n < 60, "R4 strobe drops on busy flag", n, 0);
        early = 0;
        for (int k = 0; k < 6; k++) begin
          if (done_o) early = 1;
          @(negedge clk);
        end
        chk(!early, "R4 no done while flag busy", early, 0);
        set_flag(1'b1);
        wait_done(n);
        chk(done_o, "R4 done after flag ready", done_o, 1);
      end else begin
        @(negedge clk);
        set_flag(1'b1);
        wait_done(n);
        chk(done_o, "R5 pulse-mode done", done_o, 1);
        chk(!pctl_on(), "R5 strobe dropped at done", pctl_on(), 0);
      end
      @(negedge clk);
      chk(!done_o, "R6 done one cycle", done_o, 0);
      chk(!busy_o, "R10 idle after done", busy_o, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n;
    bit seen, early;
    rst_n = 1'b0; start_i = 1'b0; dir_in_i = 1'b0; mode_pulse_i = 1'b0;
    pol_ctl = 1'b0; pol_flg = 1'b0; pol_sts = 1'b0;
    to_limit = TO_W'(200); pflg = 1'b1; psts = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !timeout_o && !sts_fail_o, "R1 reset flags", busy_o, 0);
    chk(preset_n_o && !io_o && !pctl_on(), "R1 reset lines", preset_n_o, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && preset_n_o && !pctl_o, "R1 after release", busy_o, 0);

    foreach (VEC[i]) run_vec(VEC[i]);

    // R3: flag busy at start holds the strobe back
    set_cfg(6'b010001);
    set_flag(1'b0);
    repeat (4) @(negedge clk);
    fire_start();
    early = 0;
    for (int k = 0; k < 15; k++) begin
      if (pctl_on()) early = 1;
      @(negedge clk);
    end
    chk(!early, "R3 strobe waits for ready", early, 0);
    chk(busy_o, "R10 busy while waiting", busy_o, 1);
    set_flag(1'b1);
    wait_pctl(1'b1, n);
    chk(n < 60 && io_o, "R3 strobe after ready", n, 0);
    set_flag(1'b0);
    wait_pctl(1'b0, n);
    set_flag(1'b1);
    wait_done(n);
    @(negedge clk);

    // R5: pulse mode does not wait for the flag to come back
    set_cfg(6'b100001);
    fire_start();
    wait_pctl(1'b1, n);
    set_flag(1'b0);
    wait_done(n);
    chk(done_o && !pctl_on(), "R5 done with flag still busy", done_o, 1);
    set_flag(1'b1);
    repeat (4) @(negedge clk);

    // R7: no acknowledge, strobe stalls
    to_limit = TO_W'(LIM);
    set_cfg(6'b000001);
    fire_start();
    wait_pctl(1'b1, n);
    n = 0; seen = 0;
    while (pctl_on() && n < 200) begin
      if (timeout_o) seen = 1;
      n++;
      @(negedge clk);
    end
    chk(n == LIM + 1, "R7 strobe width on stall", n, LIM + 1);
    chk(seen, "R7 timeout pulse", seen, 1);
    n = 0;
    while (!preset_n_o && n < 200) begin
      n++;
      @(negedge clk);
    end
    chk(n == RST_CYC, "R7 reset pulse width", n, RST_CYC);
    chk(!busy_o, "R7 idle after reset pulse", busy_o, 0);

    // R7: full mode, flag stuck busy after acknowledge
    set_cfg(6'b000001);
    fire_start();
    wait_pctl(1'b1, n);
    set_flag(1'b0);
    wait_pctl(1'b0, n);
    n = 0;
    while (!timeout_o && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk(timeout_o && pctl_on(), "R7 strobe set with timeout", pctl_on(), 1);
    @(negedge clk);
    chk(!pctl_on() && !preset_n_o, "R7 strobe clear, reset low", preset_n_o, 0);
    n = 0;
    while (!preset_n_o && n < 200) begin
      n++;
      @(negedge clk);
    end
    chk(n == RST_CYC, "R7 reset width after release stall", n, RST_CYC);
    set_flag(1'b1);
    repeat (4) @(negedge clk);

    // R8: zero limit never times out
    to_limit = '0;
    set_cfg(6'b000001);
    fire_start();
    wait_pctl(1'b1, n);
    seen = 0;
    for (int k = 0; k < 300; k++) begin
      if (timeout_o || !pctl_on()) seen = 1;
      @(negedge clk);
    end
    chk(!seen, "R8 watchdog disabled", seen, 0);
    set_flag(1'b0);
    wait_pctl(1'b0, n);
    set_flag(1'b1);
    wait_done(n);
    chk(done_o, "R8 transfer still completes", done_o, 1);
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule